// File: doc/BRIEF.md
# Adaptive Counting-Interval Controller

This block sets the length of each counting interval for a ratemeter that reports on a logarithmic scale. It counts pulses from a timebase. At the end of a minimum interval it compares the accumulated signal count with a selectable threshold. If the count has not yet reached the threshold, it keeps counting and doubles the elapsed time, then checks again. It repeats this for up to seven doublings, and at that point conversion is forced.

When an interval closes, the block sends a one-cycle start pulse to the log converter. It also reports how many doublings the interval took, so that the characteristic can be reduced by that amount and the result reads as a rate. On the cycle after the start pulse it pulses a clear for the external signal counter, and the next interval begins from zero.

With a 1 s timebase and the default minimum of 5 ticks, the possible stop points are 5, 10, 20, 40, 80, 160, 320 and 640 s.

Top module: `mtc_time_controller`

## Requirements
- R1: During reset and right after it, `conv_start` and `clr_cnt` are 0 and `dbl_out` is 0.
- R2: The first stop point is reached when `MIN_TICKS` ticks have accumulated. If `sig_count` is at or above the threshold there, conversion starts and `dbl_out` is 0.
- R3: Stop point k (k = 0..MAX_DBL) falls after `MIN_TICKS << k` ticks of the interval. When the threshold is not met at a stop point, the interval extends to the next stop point.
- R4: The threshold is `2**(THR_LOG0 + THR_STEP*thr_sel)`. With the defaults, `thr_sel` values 0, 1, 2 and 3 give 16, 64, 256 and 1024. The threshold counts as met when `sig_count` is greater than or equal to it.
- R5: At stop point `MAX_DBL` (640 ticks with the defaults), conversion starts whatever the count, and `dbl_out` equals `MAX_DBL`.
- R6: `conv_start` is high for exactly one clock. That clock is the one that follows the clock edge where the tick completing the chosen stop point was sampled.
- R7: `clr_cnt` is high for exactly one clock, immediately after `conv_start`. The next interval counts its ticks from zero.
- R8: `dbl_out` changes only together with `conv_start`, and it holds its value until the next conversion.
- R9: The threshold is tested only at stop points. A count that crosses the threshold between two stop points does not end the interval before the next stop point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timebase pulse |
| thr_sel | input | 2 | Selects the count threshold |
| sig_count | input | CNT_W | Current value of the external signal counter |
| conv_start | output | 1 | One-cycle start pulse to the log converter |
| clr_cnt | output | 1 | One-cycle clear for the external signal counter |
| dbl_out | output | DBL_W | Number of doublings used by the last interval |

## Verification
The assertions assume three things about the inputs. `tick` is a single-cycle pulse. `sig_count` comes from a counter that the block itself clears. No tick arrives in the clock where `clr_cnt` is high. The stimulus holds to these assumptions: it drives each tick for one clock with an idle clock after it, and after each conversion it waits until the clear has passed before the next tick. The sweep covers every threshold setting against a range of pulse rates, with a model counter that steps at each tick. It adds static counts lying exactly on and just below each threshold, which exercise the comparison edge and the forced stop.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

  // tick count at which stop point k is reached
  function automatic int unsigned stop_ticks(int unsigned tmin, int unsigned k);
    return tmin << k;
  endfunction

  // exponent of the power-of-two count threshold
  function automatic int unsigned thr_exp(int unsigned log0, int unsigned step,
                                          logic [1:0] sel);
    return log0 + step * int'(sel);
  endfunction

endpackage

// File: rtl/mtc_interval_timer.sv
module mtc_interval_timer #(
  parameter int MIN_TICKS = 5,
  parameter int MAX_DBL   = 7,
  parameter int ET_W      = 10,
  parameter int DBL_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             extend,
  input  logic             restart,
  output logic [DBL_W-1:0] dbl,
  output logic             stop_hit
);
  import mtc_pkg::*;

  localparam logic [ET_W-1:0] TMIN_V = ET_W'(MIN_TICKS);

  logic [ET_W-1:0] elapsed;
  logic [ET_W-1:0] limit;
  logic [ET_W-1:0] elapsed_nx;

  assign limit      = TMIN_V << dbl;
  assign elapsed_nx = elapsed + 1'b1;
  assign stop_hit   = tick && (elapsed_nx == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elapsed <= '0;
      dbl     <= '0;
    end else if (restart) begin
      elapsed <= '0;
      dbl     <= '0;
    end else begin
      if (tick)   elapsed <= elapsed_nx;
      if (extend) dbl     <= dbl + 1'b1;
    end
  end

  // elapsed time never runs past the active stop point
  assert_elapsed_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    elapsed < limit);

  // doubling count never exceeds its ceiling
  assert_dbl_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dbl <= DBL_W'(MAX_DBL));

  // an extension moves to the next stop point
  assert_extend_doubles_R3: assert property (@(posedge clk) disable iff (!rst_n)
    extend |=> (dbl == $past(dbl) + 1'b1));

endmodule

// File: rtl/mtc_stop_decider.sv
module mtc_stop_decider #(
  parameter int CNT_W    = 24,
  parameter int THR_LOG0 = 4,
  parameter int THR_STEP = 2,
  parameter int MAX_DBL  = 7,
  parameter int DBL_W    = 3
) (
  input  logic             stop_hit,
  input  logic [DBL_W-1:0] dbl,
  input  logic [CNT_W-1:0] sig_count,
  input  logic [1:0]       thr_sel,
  output logic             met,
  output logic             extend,
  output logic             fire
);
  import mtc_pkg::*;

  logic [CNT_W:0] thr;
  logic           last_stop;

  assign thr       = (CNT_W+1)'(1) << thr_exp(THR_LOG0, THR_STEP, thr_sel);
  assign met       = {1'b0, sig_count} >= thr;
  assign last_stop = (dbl == DBL_W'(MAX_DBL));
  assign extend    = stop_hit && !(met || last_stop);
  assign fire      = stop_hit && (met || last_stop);

endmodule

// File: rtl/mtc_conv_sequencer.sv
module mtc_conv_sequencer #(
  parameter int DBL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [DBL_W-1:0] dbl,
  output logic             conv_start,
  output logic             clr_cnt,
  output logic [DBL_W-1:0] dbl_out
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_start <= 1'b0;
      clr_cnt    <= 1'b0;
      dbl_out    <= '0;
    end else begin
      conv_start <= fire;
      clr_cnt    <= conv_start;
      if (fire) dbl_out <= dbl;
    end
  end

  assert_start_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_clear_after_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> clr_cnt);

  assert_clear_needs_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cnt |-> $past(conv_start));

  assert_dbl_out_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl_out != $past(dbl_out)) |-> conv_start);

endmodule

// File: rtl/mtc_time_controller.sv
module mtc_time_controller #(
  parameter int MIN_TICKS = 5,
  parameter int MAX_DBL   = 7,
  parameter int CNT_W     = 24,
  parameter int THR_LOG0  = 4,
  parameter int THR_STEP  = 2,
  parameter int DBL_W     = $clog2(MAX_DBL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [1:0]       thr_sel,
  input  logic [CNT_W-1:0] sig_count,
  output logic             conv_start,
  output logic             clr_cnt,
  output logic [DBL_W-1:0] dbl_out
);
  import mtc_pkg::*;

  localparam int ET_W = $clog2(stop_ticks(MIN_TICKS, MAX_DBL) + 1);

  logic [DBL_W-1:0] dbl;
  logic             stop_hit;
  logic             met;
  logic             extend;
  logic             fire;

  mtc_interval_timer #(
    .MIN_TICKS(MIN_TICKS), .MAX_DBL(MAX_DBL), .ET_W(ET_W), .DBL_W(DBL_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .extend(extend),
    .restart(fire), .dbl(dbl), .stop_hit(stop_hit)
  );

  mtc_stop_decider #(
    .CNT_W(CNT_W), .THR_LOG0(THR_LOG0), .THR_STEP(THR_STEP),
    .MAX_DBL(MAX_DBL), .DBL_W(DBL_W)
  ) u_decide (
    .stop_hit(stop_hit), .dbl(dbl), .sig_count(sig_count), .thr_sel(thr_sel),
    .met(met), .extend(extend), .fire(fire)
  );

  mtc_conv_sequencer #(.DBL_W(DBL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .fire(fire), .dbl(dbl),
    .conv_start(conv_start), .clr_cnt(clr_cnt), .dbl_out(dbl_out)
  );

  // threshold met at a stop point starts conversion with the current doublings
  assert_met_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_hit && met) |=> (conv_start && dbl_out == $past(dbl)));

  // last stop point forces conversion
  assert_forced_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_hit && dbl == DBL_W'(MAX_DBL)) |=> conv_start);

  // no conversion without a stop point
  assert_only_at_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_hit |=> !conv_start);

endmodule

// File: tb/tb_mtc_time_controller.sv
module tb_mtc_time_controller;
  localparam int TMIN = 5;
  localparam int MAXD = 7;
  localparam int CW   = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [1:0]    thr_sel = 2'd0;
  logic [CW-1:0] sig_count = '0;
  logic          conv_start;
  logic          clr_cnt;
  logic [2:0]    dbl_out;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  mtc_time_controller dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .thr_sel(thr_sel),
    .sig_count(sig_count), .conv_start(conv_start), .clr_cnt(clr_cnt),
    .dbl_out(dbl_out)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    tests = tests + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected threshold per R4
  function automatic longint thr_of(input int sel);
    return longint'(1) << (4 + 2 * sel);
  endfunction

  task automatic run_case(input int sel, input longint base, input longint rate);
    longint ticks = 0;
    longint cnt;
    int     exp_k = MAXD;
    bit     seen = 0;
    for (int k = MAXD; k >= 0; k--)
      if (base + rate * (longint'(TMIN) << k) >= thr_of(sel)) exp_k = k;
    thr_sel = 2'(sel);
    sig_count = CW'(base);
    while (!seen && ticks < 700) begin
      @(negedge clk);
      tick = 1'b1;
      ticks = ticks + 1;
      cnt = base + rate * ticks;
      sig_count = CW'(cnt);
      @(negedge clk);
      tick = 1'b0;
      if (conv_start) seen = 1;
    end
    // R3 R9: interval length equals the chosen stop point
    check("R3_R9 interval ticks", ticks, longint'(TMIN) << exp_k);
    // R2 R4 R5: doublings reported
    check("R2_R4_R5 dbl_out", dbl_out, exp_k);
    @(negedge clk);
    check("R6 start one cycle", conv_start, 0);
    check("R7 clear follows start", clr_cnt, 1);
    sig_count = '0;
    @(negedge clk);
    check("R7 clear one cycle", clr_cnt, 0);
    check("R8 dbl_out held", dbl_out, exp_k);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 conv_start in reset", conv_start, 0);
    check("R1 clr_cnt in reset", clr_cnt, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 dbl_out after reset", dbl_out, 0);
    check("R1 conv_start after reset", conv_start, 0);
    for (int s = 0; s < 4; s++) begin
      run_case(s, 0, 0);             // R5 forced stop
      run_case(s, 0, 1);
      run_case(s, 0, 2);
      run_case(s, 0, 3);
      run_case(s, 0, 7);
      run_case(s, 0, 20);
      run_case(s, 0, 100);
      run_case(s, 0, 300);
      run_case(s, thr_of(s), 0);     // R4 exactly at threshold
      run_case(s, thr_of(s) - 1, 0); // R4 one below forces R5
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule